// File: doc/BRIEF.md
# Byte ALU with borrow-subtract and nibble-swap

This block carries out two byte-wide register instructions on an 8-bit datapath: a subtract that chains a borrow through the carry flag, and an exchange of the two nibbles of a byte. It holds a working register, a five-bit flag register, a bank register and a banked byte memory. Each 16-bit instruction word is taken in on the first of four fixed phases. The second phase reads the file register, the third computes, and the fourth writes the result to the working register or back to memory and updates the flags.

The file address is eight bits wide. An access flag in the instruction picks between a fixed access window and a full bank chosen by the bank register. A preset port loads the working register, the bank register or the flags between instructions. A second memory port loads and reads back the byte memory.

Top module: `byte_alu_core`

## Requirements
- R1: A synchronous active-high reset sets the working register, the flags (status_out) and the bank register to zero and returns phase_out to 0.
- R2: phase_out steps 0, 1, 2, 3 and wraps, one step per clock. An instruction is sampled on the edge that ends phase 0. Its result and flags become visible after the edge that ends phase 3, and not before.
- R3: Instruction word bits [15:10] = 010110 select subtract-with-borrow. The result is (file − W − (1 − C)) modulo 256, where C is status_out bit 0.
- R4: After a subtract, status bit 0 (C) is 1 when no borrow leaves bit 7. Status bit 1 (DC) is 1 when no borrow leaves bit 3.
- R5: After a subtract, status bit 4 (N) equals result bit 7 and status bit 2 (Z) is 1 for a zero result. Status bit 3 (OV) is 1 when the signed difference falls outside −128..127.
- R6: Bits [15:10] = 001110 select the nibble swap. The result is {file[3:0], file[7:4]} and the flags are left unchanged.
- R7: When instruction bit 9 is 0 the result goes to the working register and memory is unchanged. When bit 9 is 1 the result overwrites the addressed byte and the working register is unchanged.
- R8: When instruction bit 8 is 0 the bank register is ignored. File addresses 0x00–0x7F map to bank 0 and 0x80–0xFF map to the top bank (all ones).
- R9: When instruction bit 8 is 1 the memory address is {bank register, file address}.
- R10: Any other opcode, or an instruction offered with instr_valid low, writes nothing and leaves the working register and the flags unchanged.
- R11: When a preset of the working register or the flags (set_sel 1 = W, 2 = bank, 3 = flags) arrives in the cycle an instruction writes that same register, the instruction's value wins.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| instr_word | input | 16 | Instruction word, sampled at the end of phase 0 |
| instr_valid | input | 1 | Marks instr_word as an instruction to execute |
| set_sel | input | 2 | Preset target: 0 none, 1 W, 2 bank register, 3 flags |
| set_data | input | 8 | Preset value |
| ext_we | input | 1 | Memory load strobe on the second port |
| ext_addr | input | BANK_W+8 | Second-port memory address |
| ext_wdata | input | 8 | Second-port write data |
| ext_rdata | output | 8 | Second-port read data, one cycle after the address |
| w_out | output | 8 | Working register |
| status_out | output | 5 | Flags {N, OV, Z, DC, C} |
| phase_out | output | 2 | Current phase of the instruction cycle |

## Verification
The phase-3 writeback can fall in the same clock as a preset of the working register or the flags. The bench provokes this by driving set_sel during phase 3 of a running subtract. It then judges the case by comparing w_out and status_out with the arithmetic result rather than the preset value. A second overlap is a subtract issued in the very next cycle after a swap has written the same byte. That subtract must read the freshly written value, and the bench checks that its result is computed from the swapped byte.

// File: rtl/byte_alu_pkg.sv
package byte_alu_pkg;
  localparam int BYTE_W = 8;
  localparam int FILE_W = 8;
  localparam int FLAG_W = 5;
  localparam int INSTR_W = 16;

  localparam logic [1:0] PH_DEC = 2'd0;
  localparam logic [1:0] PH_RD  = 2'd1;
  localparam logic [1:0] PH_EXE = 2'd2;
  localparam logic [1:0] PH_WR  = 2'd3;

  localparam logic [1:0] SEL_NONE  = 2'd0;
  localparam logic [1:0] SEL_W     = 2'd1;
  localparam logic [1:0] SEL_BANK  = 2'd2;
  localparam logic [1:0] SEL_FLAGS = 2'd3;

  localparam logic [5:0] OPC_SUBB = 6'b010110;
  localparam logic [5:0] OPC_SWAP = 6'b001110;

  localparam int BIT_DEST = 9;
  localparam int BIT_BANK = 8;

  typedef enum logic [1:0] {OP_NONE, OP_SUBB, OP_SWAP} op_kind_t;

  function automatic op_kind_t decode_op(input logic [INSTR_W-1:0] word, input logic vld);
    op_kind_t k;
    k = OP_NONE;
    if (vld) begin
      if (word[15:10] == OPC_SUBB) k = OP_SUBB;
      else if (word[15:10] == OPC_SWAP) k = OP_SWAP;
    end
    return k;
  endfunction
endpackage

// File: rtl/file_addr_gen.sv
module file_addr_gen
  import byte_alu_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic [FILE_W-1:0]        file_sel,
  input  logic                     use_bank,
  input  logic [BANK_W-1:0]        bank_q,
  output logic [BANK_W+FILE_W-1:0] phys_addr
);
  logic [BANK_W-1:0] bank_pick;

  always_comb begin
    if (use_bank) bank_pick = bank_q;
    else          bank_pick = {BANK_W{file_sel[FILE_W-1]}};
    phys_addr = {bank_pick, file_sel};
  end
endmodule

// File: rtl/subswap_alu.sv
module subswap_alu
  import byte_alu_pkg::*;
(
  input  op_kind_t            op,
  input  logic [BYTE_W-1:0]   f_val,
  input  logic [BYTE_W-1:0]   w_val,
  input  logic                c_in,
  output logic [BYTE_W-1:0]   res,
  output logic [FLAG_W-1:0]   flags
);
  localparam int HALF = BYTE_W / 2;

  logic [BYTE_W:0] sum_full;
  logic [HALF:0]   sum_low;
  logic            ov;

  always_comb begin
    sum_full = {1'b0, f_val} + {1'b0, ~w_val} + {{BYTE_W{1'b0}}, c_in};
    sum_low  = {1'b0, f_val[HALF-1:0]} + {1'b0, ~w_val[HALF-1:0]} + {{HALF{1'b0}}, c_in};
    if (op == OP_SWAP) res = {f_val[HALF-1:0], f_val[BYTE_W-1:HALF]};
    else               res = sum_full[BYTE_W-1:0];
    ov = (f_val[BYTE_W-1] ^ w_val[BYTE_W-1]) & (sum_full[BYTE_W-1] ^ f_val[BYTE_W-1]);
    flags = {sum_full[BYTE_W-1], ov, (sum_full[BYTE_W-1:0] == '0), sum_low[HALF], sum_full[BYTE_W]};
  end

  // R4: carry-out means "no borrow", i.e. f covers W plus the pending borrow
  always_comb begin
    assert_borrow_R4: assert (flags[0] == ({1'b0, f_val} >= ({1'b0, w_val} + {{BYTE_W{1'b0}}, ~c_in})));
  end
endmodule

// File: rtl/banked_ram.sv
module banked_ram #(
  parameter int ADDR_W = 12,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] a_addr,
  input  logic              a_we,
  input  logic [DATA_W-1:0] a_wdata,
  output logic [DATA_W-1:0] a_rdata,
  input  logic [ADDR_W-1:0] b_addr,
  input  logic              b_we,
  input  logic [DATA_W-1:0] b_wdata,
  output logic [DATA_W-1:0] b_rdata
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (a_we) mem[a_addr] <= a_wdata;
    if (b_we) mem[b_addr] <= b_wdata;
    a_rdata <= mem[a_addr];
    b_rdata <= mem[b_addr];
  end
endmodule

// File: rtl/byte_alu_core.sv
module byte_alu_core
  import byte_alu_pkg::*;
#(
  parameter int BANK_W = 4
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [15:0]              instr_word,
  input  logic                     instr_valid,
  input  logic [1:0]               set_sel,
  input  logic [7:0]               set_data,
  input  logic                     ext_we,
  input  logic [BANK_W+7:0]        ext_addr,
  input  logic [7:0]               ext_wdata,
  output logic [7:0]               ext_rdata,
  output logic [7:0]               w_out,
  output logic [4:0]               status_out,
  output logic [1:0]               phase_out
);
  localparam int ADDR_W = BANK_W + FILE_W;

  logic [1:0]          phase_q;
  logic [INSTR_W-1:0]  ir_q;
  logic                ir_vld_q;
  op_kind_t            op_k;
  logic [BYTE_W-1:0]   w_q;
  logic [FLAG_W-1:0]   status_q;
  logic [BANK_W-1:0]   bank_q;
  logic [ADDR_W-1:0]   file_addr;
  logic [BYTE_W-1:0]   rd_byte;
  logic [BYTE_W-1:0]   alu_res;
  logic [FLAG_W-1:0]   alu_flags;
  logic [BYTE_W-1:0]   res_q;
  logic [FLAG_W-1:0]   flags_q;
  logic                ram_we;

  // Phase sequencer: decode, read, execute, write
  always_ff @(posedge clk) begin
    if (rst) phase_q <= PH_DEC;
    else     phase_q <= phase_q + 2'd1;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ir_q     <= '0;
      ir_vld_q <= 1'b0;
    end else if (phase_q == PH_DEC) begin
      ir_q     <= instr_word;
      ir_vld_q <= instr_valid;
    end
  end

  always_comb op_k = decode_op(ir_q, ir_vld_q);

  file_addr_gen #(.BANK_W(BANK_W)) u_addr (
    .file_sel  (ir_q[FILE_W-1:0]),
    .use_bank  (ir_q[BIT_BANK]),
    .bank_q    (bank_q),
    .phys_addr (file_addr)
  );

  always_comb ram_we = (phase_q == PH_WR) && (op_k != OP_NONE) && ir_q[BIT_DEST];

  banked_ram #(.ADDR_W(ADDR_W), .DATA_W(BYTE_W)) u_ram (
    .clk     (clk),
    .a_addr  (file_addr),
    .a_we    (ram_we),
    .a_wdata (res_q),
    .a_rdata (rd_byte),
    .b_addr  (ext_addr),
    .b_we    (ext_we),
    .b_wdata (ext_wdata),
    .b_rdata (ext_rdata)
  );

  subswap_alu u_alu (
    .op    (op_k),
    .f_val (rd_byte),
    .w_val (w_q),
    .c_in  (status_q[0]),
    .res   (alu_res),
    .flags (alu_flags)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      res_q   <= '0;
      flags_q <= '0;
    end else if (phase_q == PH_EXE) begin
      res_q   <= alu_res;
      flags_q <= alu_flags;
    end
  end

  // Architectural registers; instruction writeback outranks presets
  always_ff @(posedge clk) begin
    if (rst) begin
      w_q      <= '0;
      status_q <= '0;
      bank_q   <= '0;
    end else begin
      if (phase_q == PH_WR && op_k != OP_NONE && !ir_q[BIT_DEST]) w_q <= res_q;
      else if (set_sel == SEL_W) w_q <= set_data;

      if (phase_q == PH_WR && op_k == OP_SUBB) status_q <= flags_q;
      else if (set_sel == SEL_FLAGS) status_q <= set_data[FLAG_W-1:0];

      if (set_sel == SEL_BANK) bank_q <= set_data[BANK_W-1:0];
    end
  end

  always_comb begin
    w_out      = w_q;
    status_out = status_q;
    phase_out  = phase_q;
  end

  assert_phase_step_R2: assert property (@(posedge clk) disable iff (rst)
    1'b1 |=> phase_q == $past(phase_q) + 2'd1);

  assert_swap_flags_R6: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WR && op_k == OP_SWAP && set_sel != SEL_FLAGS) |=> $stable(status_q));

  assert_w_hold_R7: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WR && op_k != OP_NONE && ir_q[BIT_DEST] && set_sel != SEL_W) |=> $stable(w_q));

  assert_access_window_R8: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_RD && !ir_q[BIT_BANK]) |->
      ($countones(file_addr[ADDR_W-1:FILE_W]) == 0 || $countones(file_addr[ADDR_W-1:FILE_W]) == BANK_W));

  assert_nop_quiet_R10: assert property (@(posedge clk) disable iff (rst)
    (phase_q == PH_WR && op_k == OP_NONE && set_sel == SEL_NONE) |=> ($stable(w_q) && $stable(status_q)));
endmodule

// File: tb/tb_byte_alu_core.sv
`timescale 1ns/1ps
module tb_byte_alu_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [15:0] instr_word = '0;
  logic        instr_valid = 1'b0;
  logic [1:0]  set_sel = 2'd0;
  logic [7:0]  set_data = '0;
  logic        ext_we = 1'b0;
  logic [11:0] ext_addr = '0;
  logic [7:0]  ext_wdata = '0;
  logic [7:0]  ext_rdata;
  logic [7:0]  w_out;
  logic [4:0]  status_out;
  logic [1:0]  phase_out;

  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #2 clk = ~clk;

  byte_alu_core #(.BANK_W(4)) dut (
    .clk(clk), .rst(rst), .instr_word(instr_word), .instr_valid(instr_valid),
    .set_sel(set_sel), .set_data(set_data), .ext_we(ext_we), .ext_addr(ext_addr),
    .ext_wdata(ext_wdata), .ext_rdata(ext_rdata), .w_out(w_out),
    .status_out(status_out), .phase_out(phase_out)
  );

  task automatic check(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  function automatic logic [15:0] mk(input logic [5:0] opc, input bit d, input bit a, input logic [7:0] f);
    return {opc, d, a, f};
  endfunction

  // Reference: {flags[4:0], result[7:0]} for subtract-with-borrow
  function automatic logic [12:0] ref_sub(input int f, input int w, input int c);
    int b, dd, r, lo, sf, sw, sd;
    logic [4:0] fl;
    b  = 1 - c;
    dd = f - w - b;
    r  = (dd + 512) % 256;
    lo = (f % 16) - (w % 16) - b;
    sf = (f > 127) ? f - 256 : f;
    sw = (w > 127) ? w - 256 : w;
    sd = sf - sw - b;
    fl[0] = (dd >= 0);
    fl[1] = (lo >= 0);
    fl[2] = (r == 0);
    fl[3] = (sd > 127 || sd < -128);
    fl[4] = (r >= 128);
    return {fl, r[7:0]};
  endfunction

  task automatic preset(input logic [1:0] sel, input logic [7:0] val);
    set_sel = sel; set_data = val;
    @(negedge clk);
    set_sel = 2'd0;
  endtask

  task automatic mem_wr(input logic [11:0] addr, input logic [7:0] val);
    ext_we = 1'b1; ext_addr = addr; ext_wdata = val;
    @(negedge clk);
    ext_we = 1'b0;
  endtask

  task automatic mem_rd(input logic [11:0] addr, output logic [7:0] val);
    ext_addr = addr;
    @(negedge clk);
    val = ext_rdata;
  endtask

  task automatic exec(input logic [15:0] iw, input bit vld);
    while (phase_out != 2'd0) @(negedge clk);
    instr_word = iw; instr_valid = vld;
    @(negedge clk);
    instr_valid = 1'b0;
    repeat (3) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [7:0] rv;
    logic [12:0] ex;
    logic [4:0] st;
    logic [7:0] wv;
    repeat (3) @(negedge clk);
    check("R1 W after reset", w_out, 0);
    check("R1 flags after reset", status_out, 0);
    check("R1 phase after reset", phase_out, 0);
    rst = 1'b0;

    // R1: bank register is zero, so a=1 with f=0x12 reaches 0x012
    mem_wr(12'h012, 8'h5A);
    exec(mk(OPC_SWAP_T, 0, 1, 8'h12), 1);
    check("R1 bank zero after reset", w_out, 8'hA5);

    // R2: phase order and result timing
    mem_wr(12'h040, 8'h3C);
    preset(2'd1, 8'h11);
    while (phase_out != 2'd0) @(negedge clk);
    instr_word = mk(OPC_SWAP_T, 0, 0, 8'h40); instr_valid = 1'b1;
    @(negedge clk); instr_valid = 1'b0;
    check("R2 phase 1", phase_out, 1);
    @(negedge clk);
    check("R2 phase 2", phase_out, 2);
    @(negedge clk);
    check("R2 phase 3", phase_out, 3);
    check("R2 W not yet written", w_out, 8'h11);
    @(negedge clk);
    check("R2 phase wraps", phase_out, 0);
    check("R2 W written after phase 3", w_out, 8'hC3);

    // R3 R4 R5 R7: subtract sweep at file 0x20, access window
    for (int fi = 0; fi < 16; fi++) begin
      for (int wi = 0; wi < 16; wi++) begin
        for (int c = 0; c < 2; c++) begin
          int fv, wv2;
          bit d;
          fv  = (fi * 73) % 256;
          wv2 = (wi * 89 + 5) % 256;
          d   = (fi + wi + c) % 2;
          ex  = ref_sub(fv, wv2, c);
          mem_wr(12'h020, fv[7:0]);
          preset(2'd1, wv2[7:0]);
          preset(2'd3, {7'd0, c[0]});
          exec(mk(OPC_SUBB_T, d, 0, 8'h20), 1);
          check("R4 R5 flags after subtract", status_out, ex[12:8]);
          if (!d) begin
            check("R3 result in W", w_out, ex[7:0]);
            mem_rd(12'h020, rv);
            check("R7 memory kept when d=0", rv, fv);
          end else begin
            check("R7 W kept when d=1", w_out, wv2);
            mem_rd(12'h020, rv);
            check("R3 result in memory", rv, ex[7:0]);
          end
        end
      end
    end

    // R5: signed overflow corners with literal expectations
    mem_wr(12'h020, 8'h80); preset(2'd1, 8'h01); preset(2'd3, 8'h01);
    exec(mk(OPC_SUBB_T, 0, 0, 8'h20), 1);
    check("R5 0x80-0x01 result", w_out, 8'h7F);
    check("R5 0x80-0x01 flags", status_out, 5'b01001);
    mem_wr(12'h020, 8'h7F); preset(2'd1, 8'hFF); preset(2'd3, 8'h01);
    exec(mk(OPC_SUBB_T, 0, 0, 8'h20), 1);
    check("R5 0x7F-0xFF result", w_out, 8'h80);
    check("R5 0x7F-0xFF flags", status_out, 5'b11010);
    mem_wr(12'h020, 8'h1B); preset(2'd1, 8'h1A); preset(2'd3, 8'h00);
    exec(mk(OPC_SUBB_T, 0, 0, 8'h20), 1);
    check("R4 borrow in gives zero", w_out, 8'h00);
    check("R4 R5 zero flags", status_out, 5'b00111);

    // R6: every byte through the swap, flags left as preset
    for (int v = 0; v < 256; v++) begin
      st = 5'((v * 7) % 32);
      mem_wr(12'h020, v[7:0]);
      preset(2'd3, {3'd0, st});
      exec(mk(OPC_SWAP_T, 0, 0, 8'h20), 1);
      check("R6 swapped byte", w_out, {v[3:0], v[7:4]});
      check("R6 flags unchanged", status_out, st);
    end

    // R8 R9: addressing
    mem_wr(12'hF90, 8'h12);
    mem_wr(12'h390, 8'h34);
    mem_wr(12'h010, 8'h56);
    mem_wr(12'hF10, 8'h78);
    preset(2'd2, 8'h03);
    exec(mk(OPC_SWAP_T, 0, 0, 8'h90), 1);
    check("R8 upper half of window in top bank", w_out, 8'h21);
    exec(mk(OPC_SWAP_T, 0, 1, 8'h90), 1);
    check("R9 bank register selects bank 3", w_out, 8'h43);
    preset(2'd2, 8'h0F);
    exec(mk(OPC_SWAP_T, 0, 0, 8'h10), 1);
    check("R8 lower half in bank 0, bank ignored", w_out, 8'h65);
    exec(mk(OPC_SWAP_T, 0, 1, 8'h10), 1);
    check("R9 bank register selects bank 15", w_out, 8'h87);
    exec(mk(OPC_SWAP_T, 1, 1, 8'h10), 1);
    mem_rd(12'hF10, rv);
    check("R9 write back to banked byte", rv, 8'h87);
    mem_rd(12'h010, rv);
    check("R9 window byte untouched", rv, 8'h56);

    // R10: unknown opcodes and invalid slots
    mem_wr(12'h020, 8'h9D); preset(2'd1, 8'h44); preset(2'd3, 8'h15);
    exec(16'hFFFF, 1);
    check("R10 W kept, all-ones word", w_out, 8'h44);
    check("R10 flags kept, all-ones word", status_out, 5'h15);
    exec(mk(6'b010111, 1, 0, 8'h20), 1);
    mem_rd(12'h020, rv);
    check("R10 memory kept, near opcode", rv, 8'h9D);
    check("R10 flags kept, near opcode", status_out, 5'h15);
    exec(mk(OPC_SUBB_T, 0, 0, 8'h20), 0);
    check("R10 W kept, valid low", w_out, 8'h44);
    check("R10 flags kept, valid low", status_out, 5'h15);
    exec(mk(OPC_SWAP_T, 1, 0, 8'h20), 0);
    mem_rd(12'h020, rv);
    check("R10 memory kept, valid low", rv, 8'h9D);

    // R11: preset arriving in the writeback cycle loses
    mem_wr(12'h020, 8'h19); preset(2'd1, 8'h0D); preset(2'd3, 8'h01);
    while (phase_out != 2'd0) @(negedge clk);
    instr_word = mk(OPC_SUBB_T, 0, 0, 8'h20); instr_valid = 1'b1;
    @(negedge clk); instr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    set_sel = 2'd1; set_data = 8'hAA;
    @(negedge clk); set_sel = 2'd0;
    check("R11 W writeback beats preset", w_out, 8'h0C);
    mem_wr(12'h020, 8'h03); preset(2'd1, 8'h0E); preset(2'd3, 8'h01);
    while (phase_out != 2'd0) @(negedge clk);
    instr_word = mk(OPC_SUBB_T, 0, 0, 8'h20); instr_valid = 1'b1;
    @(negedge clk); instr_valid = 1'b0;
    @(negedge clk);
    @(negedge clk);
    set_sel = 2'd3; set_data = 8'h1F;
    @(negedge clk); set_sel = 2'd0;
    check("R11 flag update beats preset", status_out, 5'b10000);
    check("R3 0x03-0x0E result", w_out, 8'hF5);

    // R3 R7: back-to-back, subtract reads byte just swapped in memory
    mem_wr(12'h030, 8'h12); preset(2'd1, 8'h01); preset(2'd3, 8'h01);
    exec(mk(OPC_SWAP_T, 1, 0, 8'h30), 1);
    exec(mk(OPC_SUBB_T, 0, 0, 8'h30), 1);
    wv = 8'h20;
    check("R3 back-to-back uses new byte", w_out, wv);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  localparam logic [5:0] OPC_SUBB_T = 6'b010110;
  localparam logic [5:0] OPC_SWAP_T = 6'b001110;
endmodule